// File: doc/BRIEF.md
# Auto-Negotiation Progress Monitor

This block watches an auto-negotiation arbitration state machine and keeps a 4-bit record of the furthest point that machine has reached. The record is a high-water mark. Between two management reads it can only move upward. A brief drop in the arbitration stage, for example after a failed match, therefore does not hide the progress made before it. Station management reads the record through the register read path. When a negotiation stalls, that value shows how far the exchange got.

Each management read has a side effect. The read itself returns the value held at that moment. On the following clock edge the record is reloaded with the live arbitration stage, which may be lower. After a negotiation has completed, a link failure starts the process over: the record returns to idle.

All pins are plain control and status signals. There is no data stream and no back-pressure. The read strobe is a single-cycle pulse from the register interface.

Top module: `anpm_progress_monitor`

## Requirements
- R1: A synchronous active-high reset makes `status_o` 4'b0000 from the first clock edge at which `rst` is sampled high.
- R2: `status_o[2:0]` carries a stage code and `status_o[3]` is the completion bit. The stage codes are: 000 idle, 001 parallel detected, 010 parallel detection failure, 011 ability matched, 100 acknowledge match failure, 101 acknowledge matched, 110 consistency match failure, 111 consistency matched.
- R3: While `an_done_i` is high and `link_fail_i` is low, the live value is 4'b1111. 1111 is the only value `status_o` can take with bit 3 set.
- R4: When no read strobe is present and no post-completion restart occurs, a live value lower than or equal to the held value leaves `status_o` unchanged.
- R5: When no read strobe is present, a live value higher than the held value appears on `status_o` one clock after it is presented.
- R6: In the cycle where `rd_i` is high, `status_o` still shows the held value. One clock later, `status_o` equals the live value of the read cycle, even if that value is lower.
- R7: When a read strobe and a higher live stage occur in the same cycle, the reload uses that incoming live value.
- R8: `link_fail_i` makes the live value idle (0000). If the held value is 1111 while `link_fail_i` is high, `status_o` becomes 0000 one clock later.
- R9: If `link_fail_i` is high while the held value is below 1111 and no read strobe is present, `status_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| an_stage_i | input | 3 | Live arbitration stage code |
| an_done_i | input | 1 | Negotiation completed flag |
| link_fail_i | input | 1 | Link failure indication |
| rd_i | input | 1 | Management read strobe for the progress status |
| status_o | output | 4 | Held progress value |

## Verification
Every change to `status_o` becomes visible one clock after the stimulus, because only one register lies between the inputs and the output. The value returned by a read is the held value in the same cycle as the strobe.

For each stimulus cycle, the driver pushes the expected post-edge value into a queue. The monitor pops that value 2 ns after the next rising edge and compares it with `status_o`. For the read-return check, the bench samples `status_o` directly at the strobe cycle, before that cycle's clock edge.

// File: rtl/anpm_pkg.sv
package anpm_pkg;
  localparam int STAGE_W = 3;

  typedef enum logic [STAGE_W-1:0] {
    ST_IDLE       = 3'b000,
    ST_PAR_DET    = 3'b001,
    ST_PAR_FAIL   = 3'b010,
    ST_ABIL_MATCH = 3'b011,
    ST_ACK_FAIL   = 3'b100,
    ST_ACK_MATCH  = 3'b101,
    ST_CONS_FAIL  = 3'b110,
    ST_CONS_MATCH = 3'b111
  } an_stage_e;
endpackage

// File: rtl/anpm_live_code.sv
module anpm_live_code #(
  parameter int STAGE_W = anpm_pkg::STAGE_W,
  localparam int STAT_W = STAGE_W + 1
) (
  input  logic [STAGE_W-1:0] stage_i,
  input  logic               done_i,
  input  logic               link_fail_i,
  output logic [STAT_W-1:0]  live_o
);
  // A failed link is treated as idle; completion saturates every bit.
  always_comb begin
    if (link_fail_i)
      live_o = '0;
    else if (done_i)
      live_o = '1;
    else
      live_o = {1'b0, stage_i};
  end
endmodule

// File: rtl/anpm_next_sel.sv
module anpm_next_sel #(
  parameter int STAGE_W = anpm_pkg::STAGE_W,
  localparam int STAT_W = STAGE_W + 1
) (
  input  logic [STAT_W-1:0] held_i,
  input  logic [STAT_W-1:0] live_i,
  input  logic              rd_i,
  input  logic              link_fail_i,
  output logic [STAT_W-1:0] next_o
);
  localparam logic [STAT_W-1:0] COMPLETE = '1;

  logic restart;
  logic rise;

  assign restart = link_fail_i && (held_i == COMPLETE);
  assign rise    = live_i > held_i;

  always_comb begin
    if (rd_i)
      next_o = live_i;
    else if (restart)
      next_o = '0;
    else if (rise)
      next_o = live_i;
    else
      next_o = held_i;
  end
endmodule

// File: rtl/anpm_hold_reg.sv
module anpm_hold_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)
      q_o <= '0;
    else
      q_o <= d_i;
  end
endmodule

// File: rtl/anpm_progress_monitor.sv
module anpm_progress_monitor #(
  parameter int STAGE_W = anpm_pkg::STAGE_W,
  localparam int STAT_W = STAGE_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STAGE_W-1:0] an_stage_i,
  input  logic               an_done_i,
  input  logic               link_fail_i,
  input  logic               rd_i,
  output logic [STAT_W-1:0]  status_o
);
  logic [STAT_W-1:0] live;
  logic [STAT_W-1:0] next_val;

  anpm_live_code #(.STAGE_W(STAGE_W)) u_live (
    .stage_i     (an_stage_i),
    .done_i      (an_done_i),
    .link_fail_i (link_fail_i),
    .live_o      (live)
  );

  anpm_next_sel #(.STAGE_W(STAGE_W)) u_sel (
    .held_i      (status_o),
    .live_i      (live),
    .rd_i        (rd_i),
    .link_fail_i (link_fail_i),
    .next_o      (next_val)
  );

  anpm_hold_reg #(.WIDTH(STAT_W)) u_hold (
    .clk (clk),
    .rst (rst),
    .d_i (next_val),
    .q_o (status_o)
  );
endmodule

// File: rtl/anpm_progress_monitor_chk.sv
module anpm_progress_monitor_chk #(
  parameter int STAGE_W = anpm_pkg::STAGE_W,
  localparam int STAT_W = STAGE_W + 1
) (
  input logic               clk,
  input logic               rst,
  input logic [STAGE_W-1:0] an_stage_i,
  input logic               an_done_i,
  input logic               link_fail_i,
  input logic               rd_i,
  input logic [STAT_W-1:0]  status_o
);
  localparam logic [STAT_W-1:0] FULL = '1;

  logic [STAT_W-1:0] live_c;
  assign live_c = link_fail_i ? '0 : (an_done_i ? FULL : {1'b0, an_stage_i});

  p_complete_code_r3: assert property (@(posedge clk) disable iff (rst)
    status_o[STAT_W-1] |-> (status_o == FULL));

  p_no_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (!rd_i && !(link_fail_i && status_o == FULL)) |=> (status_o >= $past(status_o)));

  p_rise_r5: assert property (@(posedge clk) disable iff (rst)
    (!rd_i && !link_fail_i && live_c > status_o) |=> (status_o == $past(live_c)));

  p_reload_r6: assert property (@(posedge clk) disable iff (rst)
    rd_i |=> (status_o == $past(live_c)));

  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (link_fail_i && status_o == FULL) |=> (status_o == '0));

  p_fail_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!rd_i && link_fail_i && status_o != FULL) |=> $stable(status_o));
endmodule

bind anpm_progress_monitor anpm_progress_monitor_chk #(.STAGE_W(STAGE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .an_stage_i  (an_stage_i),
  .an_done_i   (an_done_i),
  .link_fail_i (link_fail_i),
  .rd_i        (rd_i),
  .status_o    (status_o)
);

// File: tb/anpm_progress_monitor_tb.sv
module anpm_progress_monitor_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] an_stage_i = '0;
  logic       an_done_i = 1'b0;
  logic       link_fail_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [3:0] status_o;

  int n_checks = 0;
  int n_fail = 0;
  logic [3:0] model = 4'h0;
  logic [3:0] exp_q[$];
  string      tag_q[$];
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  anpm_progress_monitor u_dut (
    .clk(clk), .rst(rst), .an_stage_i(an_stage_i), .an_done_i(an_done_i),
    .link_fail_i(link_fail_i), .rd_i(rd_i), .status_o(status_o)
  );

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: status_o=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected post-edge value.
  task automatic step(input logic r, input logic [2:0] st, input logic dn,
                      input logic lf, input logic rd, input string tag);
    logic [3:0] live;
    logic [3:0] nxt;
    @(negedge clk);
    if (rd && !r) check(status_o, model, "R6 read returns held value");
    rst = r; an_stage_i = st; an_done_i = dn; link_fail_i = lf; rd_i = rd;
    live = lf ? 4'h0 : (dn ? 4'hF : {1'b0, st});
    if (r)                      nxt = 4'h0;
    else if (rd)                nxt = live;
    else if (lf && model == 4'hF) nxt = 4'h0;
    else if (live > model)      nxt = live;
    else                        nxt = model;
    model = nxt;
    exp_q.push_back(nxt);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares one queued item per clock.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(status_o, e, t);
      end
    end
  end

  initial begin
    step(1, 3'd0, 0, 0, 0, "R1 reset");
    step(1, 3'd5, 1, 0, 0, "R1 reset ignores inputs");
    for (int s = 1; s < 8; s++) step(0, s[2:0], 0, 0, 0, "R2 stage code rises");
    step(0, 3'd0, 0, 0, 1, "R6 read reload lower");
    step(0, 3'd1, 0, 0, 0, "R5 rise to parallel detected");
    step(0, 3'd3, 0, 0, 0, "R5 rise to ability matched");
    step(0, 3'd1, 0, 0, 0, "R4 lower stage ignored");
    step(0, 3'd0, 0, 0, 0, "R4 idle ignored");
    step(0, 3'd5, 0, 0, 0, "R5 rise to ack matched");
    step(0, 3'd2, 0, 0, 1, "R6 reload to lower stage");
    step(0, 3'd1, 0, 0, 0, "R4 held after reload");
    step(0, 3'd7, 0, 0, 1, "R7 read with higher stage");
    step(0, 3'd7, 1, 0, 0, "R3 completion 1111");
    step(0, 3'd0, 0, 0, 0, "R4 complete held");
    step(0, 3'd0, 0, 1, 0, "R8 link fail restarts");
    step(0, 3'd6, 0, 1, 0, "R8 link fail counts as idle");
    step(0, 3'd4, 0, 0, 0, "R5 rise after restart");
    step(0, 3'd7, 1, 1, 0, "R9 link fail below complete holds");
    step(0, 3'd6, 0, 1, 1, "R8 read during link fail gives idle");
    step(0, 3'd0, 1, 0, 1, "R7 read with completion");
    step(0, 3'd3, 0, 0, 0, "R4 complete held again");
    step(1, 3'd3, 0, 0, 0, "R1 reset from complete");
    step(0, 3'd6, 0, 0, 0, "R5 rise after reset");
    @(negedge clk);
    rd_i = 1'b0; link_fail_i = 1'b0; an_done_i = 1'b0;
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule